// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a direct-mapped lookup store that gets close to two-way conflict behaviour while keeping the single-probe hit time of a direct-mapped array. Every request first looks at its home slot. A match there is answered on the next cycle. If the home slot misses, the block looks at a partner slot. The partner's index is the home index with its top bit inverted. A match in the partner slot is a slow hit. After a slow hit the two slots trade contents, so the same address hits fast the next time.

When both slots miss, the block asks an external refill port for the data. The refilled line goes into the home slot, and the line that was in the home slot moves to the partner slot. Each stored tag carries a flag that records whether the line sits in its own home slot or in its partner slot. Without that flag, a line held in its partner slot could be mistaken for a line that maps to that slot directly. Each response carries a code that says which path served it.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: While reset is held and on the first cycle after it, `reqReady` is 1 and `rspValid` and `fillReq` are 0. Reset marks every slot empty, so the first access to any address is a miss.
- R2: A request accepted (`reqValid` and `reqReady` both 1 at a clock edge) whose home slot holds its tag is answered one cycle later: `rspValid` is 1, `rspKind` is 1 (fast) and `rspData` is the line data.
- R3: A home-slot match also requires the stored line to be marked as home. A line parked in a slot as that slot's partner never gives a fast hit to an address whose home is that slot, even when the tags are equal.
- R4: On a home miss, the partner slot is the home index with its most significant bit inverted. A line found there, marked as parked, is returned two cycles after acceptance with `rspKind` 2 (pseudo).
- R5: After a pseudo hit, `reqReady` stays 0 during the response cycle while the two slots are exchanged. Afterwards the same address hits fast, and the line that was displaced becomes a pseudo hit.
- R6: A miss is declared only when both slots fail to match. `fillReq` then rises two cycles after acceptance, with `fillAddr` equal to the request address. Both signals hold steady until `fillValid` is seen.
- R7: One cycle after `fillValid` is sampled high, the response appears with `rspKind` 3 (miss) and `rspData` equal to `fillData`. The fetched line fills the home slot, and the line that was in the home slot moves to the partner slot. The line that was in the partner slot is dropped.
- R8: `fillValid` is ignored unless a refill is pending. It produces no response and leaves the stored lines unchanged.
- R9: `reqReady` is 0 from acceptance of any request that misses its home slot until that request has been fully handled. `rspValid` is a one-cycle pulse and is never 1 with `rspKind` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request address (tag above index) |
| reqReady | output | 1 | Block can accept a request this cycle |
| rspValid | output | 1 | Response pulse |
| rspKind | output | 2 | 1 fast hit, 2 pseudo hit, 3 miss |
| rspData | output | DATA_W | Returned line data |
| fillReq | output | 1 | Refill requested |
| fillAddr | output | ADDR_W | Address to refill |
| fillValid | input | 1 | Refill data present |
| fillData | input | DATA_W | Refill data |

## Verification
The bench builds the cache with a 3-bit index and an 8-bit address. Random addresses draw from only four tag values, so home-slot collisions, partner-slot hits and evictions of partner slots come up many times in a short run. With the small index, the two slots of a pair are index 0 and index 4. That lets directed cases park a line in slot 4 and then request a different address with the same tag whose home is slot 4, which exercises the parked-flag check. Refill latency is varied so that the hold of the refill request is exercised.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_FAST   = 2'd1,
    KIND_PSEUDO = 2'd2,
    KIND_MISS   = 2'd3
  } rspKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch request address
    logic emitFast;    // respond from home slot
    logic emitPseudo;  // respond from partner slot
    logic doSwap;      // exchange home and partner
    logic doFill;      // write refill, relocate home line
  } ctlStrobe_t;

endpackage

// File: rtl/pac_datapath.sv
module pac_datapath
  import pac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              primHit,
  output logic              altHit,
  output logic [ADDR_W-1:0] heldAddr,
  output logic              rspValid,
  output logic [1:0]        rspKind,
  output logic [DATA_W-1:0] rspData
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam logic [IDX_W-1:0] TOP_MASK = IDX_W'(1) << (IDX_W - 1);

  logic [SETS-1:0]   vld;
  logic [SETS-1:0]   parked;   // line sits in its partner slot
  logic [TAG_W-1:0]  tagMem  [SETS];
  logic [DATA_W-1:0] dataMem [SETS];

  logic [IDX_W-1:0] reqIdx, homeIdx, altIdx;
  logic [TAG_W-1:0] reqTag, heldTag;

  assign reqIdx  = reqAddr[IDX_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1:IDX_W];
  assign homeIdx = heldAddr[IDX_W-1:0];
  assign heldTag = heldAddr[ADDR_W-1:IDX_W];
  assign altIdx  = homeIdx ^ TOP_MASK;

  assign primHit = vld[reqIdx] && !parked[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign altHit  = vld[altIdx] && parked[altIdx] && (tagMem[altIdx] == heldTag);

  always_ff @(posedge clk) begin
    if (!rstN) heldAddr <= '0;
    else if (strobe.capture) heldAddr <= reqAddr;
  end

  // flags carry reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld    <= '0;
      parked <= '0;
    end else if (strobe.doSwap) begin
      vld[homeIdx]    <= vld[altIdx];
      vld[altIdx]     <= vld[homeIdx];
      parked[homeIdx] <= ~parked[altIdx];
      parked[altIdx]  <= ~parked[homeIdx];
    end else if (strobe.doFill) begin
      vld[homeIdx]    <= 1'b1;
      parked[homeIdx] <= 1'b0;
      vld[altIdx]     <= vld[homeIdx];
      parked[altIdx]  <= ~parked[homeIdx];
    end
  end

  // tag and data arrays need no reset
  always_ff @(posedge clk) begin
    if (strobe.doSwap) begin
      tagMem[homeIdx]  <= tagMem[altIdx];
      tagMem[altIdx]   <= tagMem[homeIdx];
      dataMem[homeIdx] <= dataMem[altIdx];
      dataMem[altIdx]  <= dataMem[homeIdx];
    end else if (strobe.doFill) begin
      tagMem[homeIdx]  <= heldTag;
      dataMem[homeIdx] <= fillData;
      tagMem[altIdx]   <= tagMem[homeIdx];
      dataMem[altIdx]  <= dataMem[homeIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= KIND_NONE;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.emitFast | strobe.emitPseudo | strobe.doFill;
      if (strobe.emitFast) begin
        rspKind <= KIND_FAST;
        rspData <= dataMem[reqIdx];
      end else if (strobe.emitPseudo) begin
        rspKind <= KIND_PSEUDO;
        rspData <= dataMem[altIdx];
      end else if (strobe.doFill) begin
        rspKind <= KIND_MISS;
        rspData <= fillData;
      end else begin
        rspKind <= KIND_NONE;
      end
    end
  end

endmodule

// File: rtl/pac_control.sv
module pac_control
  import pac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       primHit,
  input  logic       altHit,
  input  logic       fillValid,
  output logic       reqReady,
  output logic       fillReq,
  output ctlStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_SWAP, ST_FILL} ctlState_e;

  ctlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    fillReq   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (primHit) strobe.emitFast = 1'b1;
          else         nextState = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (altHit) begin
          strobe.emitPseudo = 1'b1;
          nextState = ST_SWAP;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_SWAP: begin
        strobe.doSwap = 1'b1;
        nextState = ST_IDLE;
      end
      ST_FILL: begin
        fillReq = 1'b1;
        if (fillValid) begin
          strobe.doFill = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [1:0]        rspKind,
  output logic [DATA_W-1:0] rspData,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData
);

  ctlStrobe_t strobe;
  logic       primHit, altHit;

  pac_control ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .primHit  (primHit),
    .altHit   (altHit),
    .fillValid(fillValid),
    .reqReady (reqReady),
    .fillReq  (fillReq),
    .strobe   (strobe)
  );

  pac_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .fillData(fillData),
    .primHit (primHit),
    .altHit  (altHit),
    .heldAddr(fillAddr),
    .rspValid(rspValid),
    .rspKind (rspKind),
    .rspData (rspData)
  );

endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [1:0]        rspKind,
  input logic              fillReq,
  input logic [ADDR_W-1:0] fillAddr,
  input logic              fillValid,
  input logic [DATA_W-1:0] fillData
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !rspValid && !fillReq && reqReady);

  assert_fast_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd1) |-> $past(reqValid && reqReady));

  assert_pseudo_two_cycles_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd2) |-> $past(reqValid && reqReady, 2));

  assert_swap_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd2) |-> !reqReady);

  assert_fill_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillValid) |=> fillReq && $stable(fillAddr));

  assert_miss_after_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd3) |-> $past(fillReq && fillValid));

  assert_busy_during_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !reqReady);

  assert_pulse_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspKind != 2'd0);

  assert_ignored_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillReq) |=> !rspValid);

endmodule

bind pseudo_assoc_cache pac_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pacChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspKind  (rspKind),
  .fillReq  (fillReq),
  .fillAddr (fillAddr),
  .fillValid(fillValid),
  .fillData (fillData)
);

// File: tb/pseudo_assoc_cache_test.sv
`timescale 1ns/1ps
module pseudo_assoc_cache_test;

  localparam int ADDR_W = 8;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 16;
  localparam int SETS   = 1 << IDX_W;
  localparam int HALF   = SETS / 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic              rspValid;
  logic [1:0]        rspKind;
  logic [DATA_W-1:0] rspData;
  logic              fillReq;
  logic [ADDR_W-1:0] fillAddr;
  logic              fillValid = 1'b0;
  logic [DATA_W-1:0] fillData = '0;

  int nChecks = 0;
  int nFail   = 0;

  // reference placement: full address held by each slot
  int slotAddr [SETS];
  bit slotUsed [SETS];

  always #4 clk = ~clk;

  pseudo_assoc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspKind(rspKind),
    .rspData(rspData), .fillReq(fillReq), .fillAddr(fillAddr),
    .fillValid(fillValid), .fillData(fillData)
  );

  function automatic logic [DATA_W-1:0] memWord(input int a);
    return DATA_W'(a * 40503 + 23101);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected kind from reference placement, then update it
  function automatic int predict(input int a);
    int home = a % SETS;
    int alt  = home ^ HALF;
    if (slotUsed[home] && slotAddr[home] == a) return 1;
    if (slotUsed[alt] && slotAddr[alt] == a) begin
      slotAddr[alt] = slotAddr[home]; slotUsed[alt] = slotUsed[home];
      slotAddr[home] = a; slotUsed[home] = 1'b1;
      return 2;
    end
    slotAddr[alt] = slotAddr[home]; slotUsed[alt] = slotUsed[home];
    slotAddr[home] = a; slotUsed[home] = 1'b1;
    return 3;
  endfunction

  task automatic access(input int a, input int fillDelay);
    int expKind, n, waitLeft;
    expKind = predict(a);
    waitLeft = fillDelay;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'(a);
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (!rspValid && n < 40) begin
      if (fillReq) begin
        check(fillAddr == ADDR_W'(a), "R6 fillAddr", fillAddr, a);
        check(!reqReady, "R9 ready low while refill pending", reqReady, 0);
        if (waitLeft > 0) waitLeft--;
        else begin
          fillValid = 1'b1;
          fillData  = memWord(a);
        end
      end
      @(negedge clk);
      fillValid = 1'b0;
      n++;
    end
    check(rspKind == 2'(expKind), (expKind == 1) ? "R2 kind fast" :
          (expKind == 2) ? "R4 kind pseudo" : "R7 kind miss", rspKind, expKind);
    check(rspData == memWord(a), "R7 response data", rspData, memWord(a));
    if (expKind == 1) check(n == 1, "R2 latency", n, 1);
    if (expKind == 2) begin
      check(n == 2, "R4 latency", n, 2);
      check(!reqReady, "R5 ready low during swap", reqReady, 0);
    end
    if (expKind == 3) check(n == 3 + fillDelay, "R6 miss latency", n, 3 + fillDelay);
    @(negedge clk);
    check(!rspValid, "R9 response is a single pulse", rspValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int seedv;
    for (int i = 0; i < SETS; i++) begin slotUsed[i] = 1'b0; slotAddr[i] = 0; end
    seedv = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !fillReq, "R1 outputs in reset", {reqReady, rspValid, fillReq}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !fillReq, "R1 outputs after reset", {reqReady, rspValid, fillReq}, 3'b100);

    // R1: cold miss, then fast
    access(8'h08, 0);   // tag1, idx0
    access(8'h08, 0);   // R2 fast
    // R6: delayed refill
    access(8'h10, 3);   // tag2, idx0: A parked in slot 4
    access(8'h08, 0);   // R4 pseudo hit from slot 4, then swap
    access(8'h08, 0);   // R5 now fast
    access(8'h10, 0);   // R5 displaced line pseudo
    access(8'h08, 2);   // pseudo again after swap back
    // R3: tag1 idx4 must not hit the parked tag1 line in slot 4
    access(8'h10, 0);   // tag2 home, tag1 parked in slot 4
    access(8'h0C, 0);   // tag1 idx4: R3 miss expected
    access(8'h08, 0);   // R7 relocated line
    // R8: stray refill strobe while idle
    @(negedge clk);
    fillValid = 1'b1; fillData = 16'hDEAD;
    @(negedge clk);
    fillValid = 1'b0;
    check(!rspValid && !fillReq, "R8 stray fillValid ignored", rspValid, 0);
    access(8'h08, 0);   // R8 contents unchanged

    for (int k = 0; k < 300; k++) begin
      int a = ($urandom_range(0, 3) << IDX_W) | $urandom_range(0, SETS - 1);
      access(a, $urandom_range(0, 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule